// File: doc/BRIEF.md
# Banked Memory Management Unit

This block sits between a processor with a 16-bit address bus and a 512K physical memory. It cuts the 64K processor space into eight 8K slots. Address bits 15:13 pick a slot and bits 12:0 pass through unchanged as the offset inside the bank. Each slot is backed by a programmable bank register, so the block produces a 19-bit physical address, made of a 6-bit bank number and the 13-bit offset. Two complete sets of eight bank registers exist. A task-select control bit decides which set maps the processor space, so software can switch between two contexts in one write.

A configuration write sets four things: the translation enable, the task bit, a constant-page bit and a 2-bit ROM layout field. With the constant-page bit set, the 256-byte window 0xFE00–0xFEFF always reaches the last RAM page, whatever slot 7 holds. Two strobe inputs switch the block between ROM/RAM mode and all-RAM mode. In ROM/RAM mode, bank numbers 0x3C–0x3F drive one of two ROM chip selects in place of RAM. The slot number supplies the low two bits of the ROM page, so the programmed low bits are ignored. Bank registers can be read back through a register port.

Top module: `bank_mmu_top`

## Requirements
- R1: With translation enabled, all-RAM mode and no constant-page hit, `phys_addr` equals {bank register[5:0] of the active task for slot cpu_addr[15:13], cpu_addr[12:0]} and `ram_sel` is high.
- R2: `task_sel` 0 maps through registers at index 0–7 and `task_sel` 1 through index 8–15. On the register port, `reg_idx[3]` is the task and `reg_idx[2:0]` the slot, and both sets can be written whichever task is active.
- R3: With translation disabled, slot n maps to bank 0x38+n.
- R4: With the constant-page bit set, any address 0xFE00–0xFEFF gives `phys_addr` = 0x7E000 + cpu_addr[12:0] with `ram_sel` high. This holds regardless of task, enable or ROM/RAM mode. 0xFDFF and 0xFF00 are not affected.
- R5: In ROM/RAM mode, a bank number in 0x3C–0x3F selects ROM. The physical bank becomes {4'b1111, slot[1:0]}, so the programmed low two bits are ignored.
- R6: ROM layout field `cfg_rom_map`: with 00 or 01, ROM pages with slot[1:0] = 0 or 1 go to `irom_sel` and pages with 2 or 3 go to `erom_sel`. With 10, every ROM page goes to `irom_sel`. With 11, every ROM page goes to `erom_sel`. Exactly one of the three selects is high at all times.
- R7: A pulse on `rom_mode_stb` enters ROM/RAM mode from the next cycle, and a pulse on `ram_mode_stb` enters all-RAM mode. If both arrive in the same cycle, all-RAM mode wins.
- R8: `reg_rdata` returns the stored 6-bit bank number for `reg_idx`, with bits 7:6 always zero, even when 1s were written there.
- R9: Under reset, all bank registers are 0, translation is disabled, task is 0, the constant-page bit is 0, the ROM layout is 00 and ROM/RAM mode is active. The reset release passes through two synchronising flops.
- R10: A bank or configuration write takes effect on the translation one cycle after it is presented. An access in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| reg_wr | input | 1 | Bank register write enable |
| reg_idx | input | 4 | Bank register index {task, slot} for write and read |
| reg_wdata | input | 8 | Bank register write data (bits 5:0 kept) |
| reg_rdata | output | 8 | Bank register read data, bits 7:6 zero |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_mmu_en | input | 1 | Translation enable value |
| cfg_task | input | 1 | Task-select value |
| cfg_const_pg | input | 1 | Constant-page enable value |
| cfg_rom_map | input | 2 | ROM layout value |
| rom_mode_stb | input | 1 | Enter ROM/RAM mode |
| ram_mode_stb | input | 1 | Enter all-RAM mode |
| phys_addr | output | 19 | Physical address |
| ram_sel | output | 1 | RAM chip select |
| irom_sel | output | 1 | Internal ROM select |
| erom_sel | output | 1 | External ROM select |

## Verification
Two kinds of events can fall in the same cycle. The first is a bank register write to the slot that the current processor address is using. The second is two mode strobes arriving together, or a strobe arriving alongside a configuration change. The bench provokes both on purpose and also scatters them through a long randomised phase. Its reference model updates state only after the clock edge, so a same-cycle access must still show the old mapping and the following cycle the new one. For simultaneous strobes, the model expects all-RAM mode to take priority.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  typedef enum logic [1:0] {
    MAP_SPLIT_A = 2'b00,
    MAP_SPLIT_B = 2'b01,
    MAP_ALL_INT = 2'b10,
    MAP_ALL_EXT = 2'b11
  } rom_map_e;

  typedef struct packed {
    logic ram;
    logic irom;
    logic erom;
  } chip_sel_t;
endpackage

// File: rtl/mmu_rst_sync.sv
module mmu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_wr,
  input  logic     cfg_mmu_en,
  input  logic     cfg_task,
  input  logic     cfg_const_pg,
  input  logic [1:0] cfg_rom_map,
  input  logic     rom_mode_stb,
  input  logic     ram_mode_stb,
  output logic     mmu_en,
  output logic     task_sel,
  output logic     const_pg,
  output rom_map_e rom_map,
  output logic     rom_mode
);
  logic     en_q, en_d, task_q, task_d, cpg_q, cpg_d, rom_q, rom_d;
  rom_map_e map_q, map_d;

  always_comb begin
    en_d   = en_q;
    task_d = task_q;
    cpg_d  = cpg_q;
    map_d  = map_q;
    if (cfg_wr) begin
      en_d   = cfg_mmu_en;
      task_d = cfg_task;
      cpg_d  = cfg_const_pg;
      map_d  = rom_map_e'(cfg_rom_map);
    end
    rom_d = rom_q;
    if (ram_mode_stb)      rom_d = 1'b0;
    else if (rom_mode_stb) rom_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      task_q <= 1'b0;
      cpg_q  <= 1'b0;
      map_q  <= MAP_SPLIT_A;
      rom_q  <= 1'b1;
    end else begin
      en_q   <= en_d;
      task_q <= task_d;
      cpg_q  <= cpg_d;
      map_q  <= map_d;
      rom_q  <= rom_d;
    end
  end

  assign mmu_en   = en_q;
  assign task_sel = task_q;
  assign const_pg = cpg_q;
  assign rom_map  = map_q;
  assign rom_mode = rom_q;

  // R7
  rom_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_mode_stb && !ram_mode_stb) |=> rom_mode);
  // R7
  ram_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_mode_stb |=> !rom_mode);
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int SLOTS   = 8,
  parameter int PBANK_W = 6,
  parameter int REG_W   = 8,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int NREG   = 2 * SLOTS,
  localparam int IDX_W  = SLOT_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   idx,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic               task_sel,
  input  logic [SLOT_W-1:0]  slot,
  output logic [PBANK_W-1:0] map_bank
);
  logic [PBANK_W-1:0] bank_q [NREG];
  logic               unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:PBANK_W];

  for (genvar i = 0; i < NREG; i++) begin : g_bank
    logic               hit;
    logic [PBANK_W-1:0] nxt;
    always_comb begin
      hit = wr_en && (idx == IDX_W'(i));
      nxt = hit ? wr_data[PBANK_W-1:0] : bank_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[i] <= '0;
      else        bank_q[i] <= nxt;
    end
  end

  always_comb begin
    rd_data  = {{(REG_W-PBANK_W){1'b0}}, bank_q[idx]};
    map_bank = bank_q[{task_sel, slot}];
  end

  // R10
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bank_q[$past(idx)] == $past(wr_data[PBANK_W-1:0])));
endmodule

// File: rtl/slot_xlate.sv
module slot_xlate #(
  parameter int ADDR_W  = 16,
  parameter int SLOT_W  = 3,
  parameter int PBANK_W = 6,
  parameter int PAGE_W  = 8,
  parameter logic [7:0] CPAGE = 8'hFE
) (
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               mmu_en,
  input  logic               const_pg,
  input  logic               rom_mode,
  input  logic [PBANK_W-1:0] reg_bank,
  output logic [PBANK_W-1:0] phys_bank,
  output logic               is_rom,
  output logic [1:0]         rom_page,
  output logic               const_hit
);
  localparam int OFF_W = ADDR_W - SLOT_W;

  logic [SLOT_W-1:0]  slot;
  logic [PBANK_W-1:0] raw_bank;

  always_comb begin
    slot      = cpu_addr[ADDR_W-1:OFF_W];
    const_hit = const_pg && (cpu_addr[ADDR_W-1:ADDR_W-PAGE_W] == CPAGE[PAGE_W-1:0]);
    raw_bank  = mmu_en ? reg_bank : {{(PBANK_W-SLOT_W){1'b1}}, slot};
    is_rom    = rom_mode && (&raw_bank[PBANK_W-1:2]) && !const_hit;
    rom_page  = slot[1:0];
    if (const_hit)   phys_bank = '1;
    else if (is_rom) phys_bank = {raw_bank[PBANK_W-1:2], slot[1:0]};
    else             phys_bank = raw_bank;
  end
endmodule

// File: rtl/rom_decode.sv
module rom_decode
  import mmu_pkg::*;
(
  input  logic      is_rom,
  input  logic [1:0] rom_page,
  input  rom_map_e  rom_map,
  output chip_sel_t cs
);
  always_comb begin
    cs = '{ram: 1'b1, irom: 1'b0, erom: 1'b0};
    if (is_rom) begin
      cs.ram = 1'b0;
      unique case (rom_map)
        MAP_ALL_INT: cs.irom = 1'b1;
        MAP_ALL_EXT: cs.erom = 1'b1;
        default: begin
          cs.irom = !rom_page[1];
          cs.erom =  rom_page[1];
        end
      endcase
    end
  end
endmodule

// File: rtl/bank_mmu_top.sv
module bank_mmu_top
  import mmu_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SLOT_W  = 3,
  parameter int PBANK_W = 6,
  parameter int REG_W   = 8,
  localparam int OFF_W  = ADDR_W - SLOT_W,
  localparam int PHYS_W = PBANK_W + OFF_W,
  localparam int IDX_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cfg_wr,
  input  logic              cfg_mmu_en,
  input  logic              cfg_task,
  input  logic              cfg_const_pg,
  input  logic [1:0]        cfg_rom_map,
  input  logic              rom_mode_stb,
  input  logic              ram_mode_stb,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              ram_sel,
  output logic              irom_sel,
  output logic              erom_sel
);
  logic               rst_s_n;
  logic               mmu_en, task_sel, const_pg, rom_mode;
  rom_map_e           rom_map;
  logic [PBANK_W-1:0] reg_bank, phys_bank;
  logic               is_rom, const_hit;
  logic [1:0]         rom_page;
  chip_sel_t          cs;

  mmu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  mmu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .cfg_wr(cfg_wr), .cfg_mmu_en(cfg_mmu_en),
    .cfg_task(cfg_task), .cfg_const_pg(cfg_const_pg), .cfg_rom_map(cfg_rom_map),
    .rom_mode_stb(rom_mode_stb), .ram_mode_stb(ram_mode_stb),
    .mmu_en(mmu_en), .task_sel(task_sel), .const_pg(const_pg),
    .rom_map(rom_map), .rom_mode(rom_mode));

  bank_regfile #(.SLOTS(1 << SLOT_W), .PBANK_W(PBANK_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(reg_wr), .idx(reg_idx),
    .wr_data(reg_wdata), .rd_data(reg_rdata), .task_sel(task_sel),
    .slot(cpu_addr[ADDR_W-1:OFF_W]), .map_bank(reg_bank));

  slot_xlate #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .PBANK_W(PBANK_W)) u_xlate (
    .cpu_addr(cpu_addr), .mmu_en(mmu_en), .const_pg(const_pg),
    .rom_mode(rom_mode), .reg_bank(reg_bank), .phys_bank(phys_bank),
    .is_rom(is_rom), .rom_page(rom_page), .const_hit(const_hit));

  rom_decode u_rom (
    .is_rom(is_rom), .rom_page(rom_page), .rom_map(rom_map), .cs(cs));

  assign phys_addr = {phys_bank, cpu_addr[OFF_W-1:0]};
  assign ram_sel   = cs.ram;
  assign irom_sel  = cs.irom;
  assign erom_sel  = cs.erom;

  // R6
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot({ram_sel, irom_sel, erom_sel}));
  // R4
  const_page_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (const_pg && cpu_addr[ADDR_W-1:8] == 8'hFE) |->
      (ram_sel && phys_addr[PHYS_W-1:OFF_W] == '1));
  // R5
  rom_addr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irom_sel || erom_sel) |->
      (phys_addr[PHYS_W-1:OFF_W+2] == '1 && phys_addr[OFF_W+1:OFF_W] == cpu_addr[OFF_W+1:OFF_W]));
  // R3
  dis_map_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mmu_en && !const_hit && !rom_mode) |->
      (phys_addr[PHYS_W-1:OFF_W] == {{(PBANK_W-SLOT_W){1'b1}}, cpu_addr[ADDR_W-1:OFF_W]}));
endmodule

// File: tb/sim_bank_mmu_top.sv
module sim_bank_mmu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cfg_wr = 1'b0, cfg_mmu_en = 1'b0, cfg_task = 1'b0, cfg_const_pg = 1'b0;
  logic [1:0]  cfg_rom_map = '0;
  logic        rom_mode_stb = 1'b0, ram_mode_stb = 1'b0;
  logic [18:0] phys_addr;
  logic        ram_sel, irom_sel, erom_sel;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_bank [16];
  bit m_en = 0, m_task = 0, m_cpg = 0, m_rom = 1;
  int m_map = 0;

  always #2 clk = ~clk;

  bank_mmu_top u0 (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h addr=%h", req, what, act, exp, cpu_addr);
    end
  endtask

  task automatic compare(string req);
    int slot, b, e_ram, e_irom, e_erom, pg;
    slot = int'(cpu_addr) >> 13;
    e_ram = 1; e_irom = 0; e_erom = 0;
    if (m_cpg && (int'(cpu_addr) >> 8) == 'hFE) b = 63;
    else begin
      b = m_en ? m_bank[(m_task ? 8 : 0) + slot] : 56 + slot;
      if (m_rom && b >= 60) begin
        pg = slot % 4;
        b = 60 + pg;
        e_ram = 0;
        if (m_map == 2) e_irom = 1;
        else if (m_map == 3) e_erom = 1;
        else if (pg < 2) e_irom = 1;
        else e_erom = 1;
      end
    end
    chk(req, "phys_addr", int'(phys_addr), b * 8192 + (int'(cpu_addr) % 8192));
    chk(req, "ram_sel", int'(ram_sel), e_ram);
    chk(req, "irom_sel", int'(irom_sel), e_irom);
    chk(req, "erom_sel", int'(erom_sel), e_erom);
    chk(req, "reg_rdata", int'(reg_rdata), m_bank[reg_idx]);
  endtask

  // inputs are set after a negedge; check, clock, update model, clear pulses
  task automatic step(string req);
    #1 compare(req);
    @(posedge clk);
    if (rst_n) begin
      if (reg_wr) m_bank[reg_idx] = int'(reg_wdata) % 64;
      if (cfg_wr) begin
        m_en = cfg_mmu_en; m_task = cfg_task; m_cpg = cfg_const_pg; m_map = int'(cfg_rom_map);
      end
      if (ram_mode_stb) m_rom = 0;
      else if (rom_mode_stb) m_rom = 1;
    end
    @(negedge clk);
    reg_wr = 0; cfg_wr = 0; rom_mode_stb = 0; ram_mode_stb = 0;
  endtask

  task automatic set_cfg(bit en, bit tk, bit cp, int mp, string req);
    cfg_wr = 1; cfg_mmu_en = en; cfg_task = tk; cfg_const_pg = cp; cfg_rom_map = 2'(mp);
    step(req);
  endtask

  task automatic wr_bank(int idx, int val, string req);
    reg_wr = 1; reg_idx = 4'(idx); reg_wdata = 8'(val);
    step(req);
  endtask

  task automatic sweep_slots(string req);
    for (int s = 0; s < 8; s++) begin
      cpu_addr = 16'(s * 8192 + ($urandom % 8192));
      step(req);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_bank[i] = 0;
    @(negedge clk);
    // R9: reset state, ROM/RAM mode, translation off
    cpu_addr = 16'h0123; step("R9");
    cpu_addr = 16'h8456; step("R9");
    cpu_addr = 16'hE789; step("R9");
    rst_n = 1'b1;
    repeat (4) begin cpu_addr = 16'hC000; step("R9"); end
    sweep_slots("R9");

    // R3: disabled mapping in all-RAM mode
    ram_mode_stb = 1; step("R7");
    sweep_slots("R3");

    // R1: program both tasks, enable, task 0
    for (int i = 0; i < 16; i++) wr_bank(i, $urandom % 256, "R2");
    set_cfg(1, 0, 0, 0, "R10");
    sweep_slots("R1");
    // R2: task 1
    set_cfg(1, 1, 0, 0, "R2");
    sweep_slots("R2");
    // R8: upper bits read zero
    wr_bank(5, 'hFF, "R8");
    for (int i = 0; i < 16; i++) begin reg_idx = 4'(i); step("R8"); end

    // R4: constant page with boundaries, both tasks, ROM mode
    wr_bank(15, 'h3C, "R4"); wr_bank(7, 'h3E, "R4");
    rom_mode_stb = 1; step("R7");
    for (int t = 0; t < 2; t++) begin
      set_cfg(1, t[0], 1, 0, "R4");
      cpu_addr = 16'hFE00; step("R4");
      cpu_addr = 16'hFEFF; step("R4");
      cpu_addr = 16'hFDFF; step("R4");
      cpu_addr = 16'hFF00; step("R4");
    end
    set_cfg(0, 0, 1, 3, "R4");
    cpu_addr = 16'hFE80; step("R4");

    // R5 / R6: ROM pages programmed into wrong slots, every layout
    for (int s = 0; s < 8; s++) wr_bank(s, 'h3C + ((s + 1) % 4), "R5");
    for (int mp = 0; mp < 4; mp++) begin
      set_cfg(1, 0, 0, mp, "R6");
      sweep_slots("R6");
      cpu_addr = 16'hFE10; step("R6");
    end

    // R7: simultaneous strobes, all-RAM wins
    rom_mode_stb = 1; ram_mode_stb = 1; cpu_addr = 16'h2000; step("R7");
    step("R7");
    rom_mode_stb = 1; step("R7");
    step("R7");

    // R10: write to the slot in use, same cycle and next
    cpu_addr = 16'h4321;
    wr_bank(2, 'h11, "R10");
    step("R10");
    cfg_wr = 1; cfg_mmu_en = 0; cfg_rom_map = 2'd2; step("R10");
    step("R10");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      cpu_addr = 16'($urandom);
      reg_idx = 4'($urandom);
      r = $urandom % 16;
      if (r == 0) begin
        cfg_wr = 1; cfg_mmu_en = 1'($urandom); cfg_task = 1'($urandom);
        cfg_const_pg = 1'($urandom); cfg_rom_map = 2'($urandom);
      end else if (r < 4) begin
        reg_wr = 1; reg_wdata = ($urandom % 2) ? 8'(8'h3C + $urandom % 4) : 8'($urandom);
      end
      if (r == 5) rom_mode_stb = 1;
      if (r == 6) ram_mode_stb = 1;
      if (r == 7) begin rom_mode_stb = 1; ram_mode_stb = 1; end
      step("R1");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule